// File: doc/BRIEF.md
# Integer Execute Unit with Conditional Moves

This block is the integer execute stage of a 32-bit load/store core. Each cycle it takes one instruction word, the values read from the two source registers (`srcA` for the rs field, `srcB` for the rt field) and the current contents of the destination register. It registers a result value, a write-enable and a destination index, and presents them one clock later. It handles immediate and register-register arithmetic and logic, signed and unsigned compares, signed minimum and maximum, zero-tested conditional moves, and constant and variable shifts. A logical right shift becomes a rotate when a spare field of the shift instruction is set.

Field layout: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shift amount in 10:6, function code in 5:0, and the immediate in 15:0. Register-format instructions have opcode 0 and write rd. Immediate-format instructions write rt. Add and subtract wrap modulo 2^32 and never trap.

Top module: `alu_exec`

## Requirements
- R1: Opcodes 8 and 9 both produce rs plus the sign-extended 16-bit immediate, wrapping with no overflow indication.
- R2: Opcodes 12, 13 and 14 produce rs AND, OR and XOR the zero-extended immediate. Opcode 15 produces the immediate in bits 31:16 with bits 15:0 cleared.
- R3: Opcode 10 produces 1 when rs is below the sign-extended immediate as signed values, else 0. Opcode 11 produces the same test as unsigned values, with the immediate still sign-extended first.
- R4: Functions 32 and 33 both produce rs+rt, functions 34 and 35 both produce rs-rt, each wrapping with no trap. Functions 36, 37, 38 and 39 produce AND, OR, XOR and NOR of rs and rt.
- R5: Function 42 produces 1 when rs < rt as signed values, and function 43 does the same as unsigned values. Otherwise each produces 0.
- R6: Function 44 produces the signed maximum of rs and rt, and function 45 the signed minimum.
- R7: Function 10 produces rs when rt is zero, and function 11 produces rs when rt is non-zero. When the condition fails, the result is the old destination value, so the register is unchanged.
- R8: Functions 0, 2 and 3 shift rt left logically, right logically and right arithmetically by the shift-amount field. Function 2 rotates right instead when the rs field equals 1.
- R9: Functions 4, 6 and 7 shift rt by the low 5 bits of the rs value. Function 6 rotates right instead when the shift-amount field equals 1.
- R10: The write-enable is never asserted for destination index 0.
- R11: Any other opcode or function code raises the illegal flag, clears the write-enable and gives result 0.
- R12: Outputs appear one clock after the inputs are sampled. While reset (active low) is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Instruction word |
| srcA | input | 32 | Value of register named by rs |
| srcB | input | 32 | Value of register named by rt |
| destOld | input | 32 | Current value of the destination register |
| resData | output | 32 | Registered result |
| resWe | output | 1 | Registered write-enable |
| resIdx | output | 5 | Registered destination index |
| resIllegal | output | 1 | Registered illegal-instruction flag |

## Verification
Operands are chosen at sign and magnitude boundaries: for example all-ones against small positives, and the most positive value plus one. These values tell signed behaviour apart from unsigned behaviour in compares and min/max, and show that add/subtract wrap. Sign-extended immediates are told apart from zero-extended ones by using immediates with bit 15 set. Shift amounts carry stray upper bits in the rs value to show masking. Rotates and logical shifts use the same amount, so a wrong choice shows in the upper bits. Conditional moves are run with both a zero and a non-zero rt, and with distinct old and new values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_MAX, OP_MIN, OP_LUI,
    OP_SLL, OP_SRL, OP_SRA, OP_ROR, OP_MOVZ, OP_MOVN
  } aluOp_e;

  typedef enum logic [1:0] { SRC_REG, SRC_SIMM, SRC_ZIMM } bSrc_e;

  typedef struct packed {
    aluOp_e     op;
    bSrc_e      bSrc;
    logic       varShift;
    logic [4:0] destIdx;
    logic       illegal;
  } aluCtrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [31:0] instr,
  output aluCtrl_t    ctrl
);
  logic [5:0] opcode;
  logic [5:0] funct;
  logic [4:0] rsField;
  logic [4:0] rtField;
  logic [4:0] rdField;
  logic [4:0] saField;

  assign opcode  = instr[31:26];
  assign rsField = instr[25:21];
  assign rtField = instr[20:16];
  assign rdField = instr[15:11];
  assign saField = instr[10:6];
  assign funct   = instr[5:0];

  always_comb begin
    ctrl.op       = OP_ADD;
    ctrl.bSrc     = SRC_REG;
    ctrl.varShift = 1'b0;
    ctrl.destIdx  = rdField;
    ctrl.illegal  = 1'b0;
    if (opcode == 6'd0) begin
      unique case (funct)
        6'd0:  ctrl.op = OP_SLL;
        6'd2:  ctrl.op = (rsField == 5'd1) ? OP_ROR : OP_SRL;
        6'd3:  ctrl.op = OP_SRA;
        6'd4:  begin ctrl.op = OP_SLL; ctrl.varShift = 1'b1; end
        6'd6:  begin ctrl.op = (saField == 5'd1) ? OP_ROR : OP_SRL; ctrl.varShift = 1'b1; end
        6'd7:  begin ctrl.op = OP_SRA; ctrl.varShift = 1'b1; end
        6'd10: ctrl.op = OP_MOVZ;
        6'd11: ctrl.op = OP_MOVN;
        6'd32, 6'd33: ctrl.op = OP_ADD;
        6'd34, 6'd35: ctrl.op = OP_SUB;
        6'd36: ctrl.op = OP_AND;
        6'd37: ctrl.op = OP_OR;
        6'd38: ctrl.op = OP_XOR;
        6'd39: ctrl.op = OP_NOR;
        6'd42: ctrl.op = OP_SLT;
        6'd43: ctrl.op = OP_SLTU;
        6'd44: ctrl.op = OP_MAX;
        6'd45: ctrl.op = OP_MIN;
        default: ctrl.illegal = 1'b1;
      endcase
    end else begin
      ctrl.destIdx = rtField;
      unique case (opcode)
        6'd8, 6'd9: begin ctrl.op = OP_ADD;  ctrl.bSrc = SRC_SIMM; end
        6'd10:      begin ctrl.op = OP_SLT;  ctrl.bSrc = SRC_SIMM; end
        6'd11:      begin ctrl.op = OP_SLTU; ctrl.bSrc = SRC_SIMM; end
        6'd12:      begin ctrl.op = OP_AND;  ctrl.bSrc = SRC_ZIMM; end
        6'd13:      begin ctrl.op = OP_OR;   ctrl.bSrc = SRC_ZIMM; end
        6'd14:      begin ctrl.op = OP_XOR;  ctrl.bSrc = SRC_ZIMM; end
        6'd15:      begin ctrl.op = OP_LUI;  ctrl.bSrc = SRC_SIMM; end
        default:    ctrl.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [15:0]       imm,
  input  logic [4:0]        saField,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] destOld,
  output logic [DATA_W-1:0] result,
  output logic              writeEn
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0]   simm;
  logic [DATA_W-1:0]   zimm;
  logic [DATA_W-1:0]   opB;
  logic [SH_W-1:0]     shAmt;
  logic [2*DATA_W-1:0] rotWide;
  logic                sLess;
  logic                uLess;

  assign simm = {{(DATA_W-16){imm[15]}}, imm};
  assign zimm = {{(DATA_W-16){1'b0}}, imm};

  always_comb begin
    unique case (ctrl.bSrc)
      SRC_SIMM: opB = simm;
      SRC_ZIMM: opB = zimm;
      default:  opB = srcB;
    endcase
  end

  assign shAmt   = ctrl.varShift ? srcA[SH_W-1:0] : SH_W'(saField);
  assign rotWide = {srcB, srcB} >> shAmt;
  assign sLess   = $signed(srcA) < $signed(opB);
  assign uLess   = srcA < opB;

  always_comb begin
    result = '0;
    if (!ctrl.illegal) begin
      unique case (ctrl.op)
        OP_ADD:  result = srcA + opB;
        OP_SUB:  result = srcA - opB;
        OP_AND:  result = srcA & opB;
        OP_OR:   result = srcA | opB;
        OP_XOR:  result = srcA ^ opB;
        OP_NOR:  result = ~(srcA | opB);
        OP_SLT:  result = DATA_W'(sLess);
        OP_SLTU: result = DATA_W'(uLess);
        OP_MAX:  result = sLess ? opB : srcA;
        OP_MIN:  result = sLess ? srcA : opB;
        OP_LUI:  result = simm << 16;
        OP_SLL:  result = srcB << shAmt;
        OP_SRL:  result = srcB >> shAmt;
        OP_SRA:  result = DATA_W'($signed(srcB) >>> shAmt);
        OP_ROR:  result = rotWide[DATA_W-1:0];
        OP_MOVZ: result = (srcB == '0) ? srcA : destOld;
        OP_MOVN: result = (srcB != '0) ? srcA : destOld;
        default: result = '0;
      endcase
    end
  end

  assign writeEn = !ctrl.illegal && (ctrl.destIdx != 5'd0);
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] destOld,
  output logic [DATA_W-1:0] resData,
  output logic              resWe,
  output logic [4:0]        resIdx,
  output logic              resIllegal
);
  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] dpResult;
  logic              dpWe;

  alu_ctrl u_ctrl (
    .instr (instr),
    .ctrl  (ctrl)
  );

  alu_dp #(.DATA_W(DATA_W)) u_dp (
    .ctrl    (ctrl),
    .imm     (instr[15:0]),
    .saField (instr[10:6]),
    .srcA    (srcA),
    .srcB    (srcB),
    .destOld (destOld),
    .result  (dpResult),
    .writeEn (dpWe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resData    <= '0;
      resWe      <= 1'b0;
      resIdx     <= '0;
      resIllegal <= 1'b0;
    end else begin
      resData    <= dpResult;
      resWe      <= dpWe;
      resIdx     <= ctrl.destIdx;
      resIllegal <= ctrl.illegal;
    end
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [DATA_W-1:0] destOld,
  input logic [DATA_W-1:0] resData,
  input logic              resWe,
  input logic [4:0]        resIdx,
  input logic              resIllegal
);
  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R10: no write to register 0
  p_zero_dest_r10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    resWe |-> (resIdx != 5'd0));

  // R11: illegal gives no write and zero result
  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    resIllegal |-> (!resWe && resData == '0));

  // R7: failed zero-test move keeps the old destination value
  p_movz_keep_r7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (instr[31:26] == 6'd0 && instr[5:0] == 6'd10 && srcB != '0)
      |=> (resData == $past(destOld)));

  // R2: upper-immediate load clears the low half
  p_lui_low_r2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (instr[31:26] == 6'd15) |=> (resData[15:0] == 16'h0 && resData[31:16] == $past(instr[15:0])));

  // R12: destination index follows the instruction one cycle later
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (instr[31:26] != 6'd0) |=> (resIdx == $past(instr[20:16])));
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr      (instr),
  .srcA       (srcA),
  .srcB       (srcB),
  .destOld    (destOld),
  .resData    (resData),
  .resWe      (resWe),
  .resIdx     (resIdx),
  .resIllegal (resIllegal)
);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] destOld = '0;
  logic [31:0] resData;
  logic        resWe;
  logic [4:0]  resIdx;
  logic        resIllegal;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [31:0] data;
    logic        we;
    logic [4:0]  idx;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  alu_exec u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .srcA(srcA), .srcB(srcB),
    .destOld(destOld), .resData(resData), .resWe(resWe), .resIdx(resIdx),
    .resIllegal(resIllegal)
  );

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input int sa, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sa), 6'(fn)};
  endfunction

  function automatic logic [31:0] itype(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  function automatic exp_t model(input logic [31:0] ins, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] old);
    exp_t e;
    logic [31:0] se;
    logic [31:0] ze;
    logic [4:0]  n;
    logic [4:0]  cn;
    logic        bad;
    logic [31:0] r;
    se  = {{16{ins[15]}}, ins[15:0]};
    ze  = {16'h0, ins[15:0]};
    n   = a[4:0];
    cn  = ins[10:6];
    bad = 1'b0;
    r   = 32'h0;
    if (ins[31:26] == 6'd0) begin
      e.idx = ins[15:11];
      case (ins[5:0])
        0:  r = b << cn;
        2:  r = (ins[25:21] == 5'd1) ? ((b >> cn) | (b << (6'd32 - {1'b0, cn}))) : b >> cn;
        3:  r = 32'($signed(b) >>> cn);
        4:  r = b << n;
        6:  r = (cn == 5'd1) ? ((b >> n) | (b << (6'd32 - {1'b0, n}))) : b >> n;
        7:  r = 32'($signed(b) >>> n);
        10: r = (b == 0) ? a : old;
        11: r = (b != 0) ? a : old;
        32, 33: r = a + b;
        34, 35: r = a - b;
        36: r = a & b;
        37: r = a | b;
        38: r = a ^ b;
        39: r = ~(a | b);
        42: r = ($signed(a) < $signed(b)) ? 1 : 0;
        43: r = (a < b) ? 1 : 0;
        44: r = ($signed(a) > $signed(b)) ? a : b;
        45: r = ($signed(a) < $signed(b)) ? a : b;
        default: bad = 1'b1;
      endcase
    end else begin
      e.idx = ins[20:16];
      case (ins[31:26])
        8, 9: r = a + se;
        10: r = ($signed(a) < $signed(se)) ? 1 : 0;
        11: r = (a < se) ? 1 : 0;
        12: r = a & ze;
        13: r = a | ze;
        14: r = a ^ ze;
        15: r = {ins[15:0], 16'h0};
        default: bad = 1'b1;
      endcase
    end
    e.data = bad ? 32'h0 : r;
    e.ill  = bad;
    e.we   = !bad && (e.idx != 0);
    return e;
  endfunction

  task automatic drive(input string tag, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] old);
    exp_t e;
    @(negedge clk);
    instr = ins; srcA = a; srcB = b; destOld = old;
    e = model(ins, a, b, old);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (resData !== e.data || resWe !== e.we || resIdx !== e.idx || resIllegal !== e.ill) begin
          fails++;
          $display("FAIL %s: got data=%h we=%b idx=%0d ill=%b, expected data=%h we=%b idx=%0d ill=%b",
                   e.tag, resData, resWe, resIdx, resIllegal, e.data, e.we, e.idx, e.ill);
        end
      end
    end
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    instr = rtype(1, 2, 3, 0, 32);
    srcA = 32'h1234; srcB = 32'h1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (resData !== 0 || resWe !== 0 || resIdx !== 0 || resIllegal !== 0) begin
      fails++;
      $display("FAIL R12 reset: got data=%h we=%b idx=%0d ill=%b, expected all zero",
               resData, resWe, resIdx, resIllegal);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 immediate add
    drive("R1", itype(8, 1, 4, 16'hFFFD), 32'd5, 32'h0, 32'h0);
    drive("R1", itype(9, 1, 4, 16'h0001), 32'h7FFFFFFF, 32'h0, 32'h0);
    // R2 immediate logic and upper load
    drive("R2", itype(12, 1, 5, 16'h8F0F), 32'hFFFF1234, 32'h0, 32'h0);
    drive("R2", itype(13, 1, 5, 16'h8000), 32'h00000001, 32'h0, 32'h0);
    drive("R2", itype(14, 1, 5, 16'hFFFF), 32'hF0F0F0F0, 32'h0, 32'h0);
    drive("R2", itype(15, 0, 5, 16'hABCD), 32'h55555555, 32'h0, 32'h0);
    // R3 immediate compares
    drive("R3", itype(10, 1, 6, 16'h0000), 32'hFFFFFFFF, 32'h0, 32'h0);
    drive("R3", itype(10, 1, 6, 16'hFFFF), 32'h00000002, 32'h0, 32'h0);
    drive("R3", itype(11, 1, 6, 16'hFFFF), 32'h00000005, 32'h0, 32'h0);
    drive("R3", itype(11, 1, 6, 16'hFFFF), 32'hFFFFFFFF, 32'h0, 32'h0);
    // R4 register arithmetic and logic
    drive("R4", rtype(1, 2, 7, 0, 32), 32'h7FFFFFFF, 32'h1, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 33), 32'hFFFFFFFF, 32'h2, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 34), 32'h80000000, 32'h1, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 35), 32'h0, 32'h1, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 36), 32'hFF00FF00, 32'h0FF00FF0, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 37), 32'hFF00FF00, 32'h0FF00FF0, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 38), 32'hFF00FF00, 32'h0FF00FF0, 32'h0);
    drive("R4", rtype(1, 2, 7, 0, 39), 32'hFF00FF00, 32'h0FF00FF0, 32'h0);
    // R5 register compares
    drive("R5", rtype(1, 2, 8, 0, 42), 32'hFFFFFFFE, 32'h1, 32'h0);
    drive("R5", rtype(1, 2, 8, 0, 43), 32'hFFFFFFFE, 32'h1, 32'h0);
    drive("R5", rtype(1, 2, 8, 0, 42), 32'h3, 32'h3, 32'h0);
    // R6 signed min/max
    drive("R6", rtype(1, 2, 9, 0, 44), 32'hFFFFFFFB, 32'h3, 32'h0);
    drive("R6", rtype(1, 2, 9, 0, 45), 32'hFFFFFFFB, 32'h3, 32'h0);
    drive("R6", rtype(1, 2, 9, 0, 44), 32'h80000000, 32'h7FFFFFFF, 32'h0);
    // R7 conditional moves
    drive("R7", rtype(1, 2, 10, 0, 10), 32'hAAAA0001, 32'h0, 32'h11112222);
    drive("R7", rtype(1, 2, 10, 0, 10), 32'hAAAA0001, 32'h7, 32'h11112222);
    drive("R7", rtype(1, 2, 10, 0, 11), 32'hAAAA0001, 32'h7, 32'h11112222);
    drive("R7", rtype(1, 2, 10, 0, 11), 32'hAAAA0001, 32'h0, 32'h11112222);
    // R8 constant shifts and rotate
    drive("R8", rtype(0, 2, 11, 4, 0), 32'h0, 32'h8000000F, 32'h0);
    drive("R8", rtype(0, 2, 11, 8, 2), 32'h0, 32'h123456F0, 32'h0);
    drive("R8", rtype(1, 2, 11, 8, 2), 32'h0, 32'h123456F0, 32'h0);
    drive("R8", rtype(0, 2, 11, 8, 3), 32'h0, 32'h823456F0, 32'h0);
    // R9 variable shifts and rotate
    drive("R9", rtype(1, 2, 12, 0, 4), 32'hFFFFFFE3, 32'h00000011, 32'h0);
    drive("R9", rtype(1, 2, 12, 0, 6), 32'h00000024, 32'h876543F1, 32'h0);
    drive("R9", rtype(1, 2, 12, 1, 6), 32'h00000024, 32'h876543F1, 32'h0);
    drive("R9", rtype(1, 2, 12, 0, 7), 32'h0000003F, 32'h80000000, 32'h0);
    // R10 destination zero
    drive("R10", itype(9, 1, 0, 16'h0010), 32'h1, 32'h0, 32'h0);
    drive("R10", rtype(1, 2, 0, 0, 33), 32'h1, 32'h2, 32'h0);
    // R11 illegal
    drive("R11", itype(2, 1, 3, 16'h1234), 32'h1, 32'h2, 32'h0);
    drive("R11", rtype(1, 2, 3, 0, 1), 32'h1, 32'h2, 32'h0);
    drive("R11", rtype(1, 2, 3, 0, 24), 32'h1, 32'h2, 32'h0);

    @(negedge clk);
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule